// File: doc/BRIEF.md
# Clock Source Switch and Sleep Controller

This block chooses which of two oscillators drives the core: a slow secondary oscillator or the main oscillator. Each oscillator appears as a one-cycle tick on a fast reference clock. The block turns the ticks of the chosen source into a system clock enable and a four-phase instruction cycle, Q1 to Q4. It also gives a strobe on every instruction boundary, where the program counter moves on by one instruction (two bytes).

A change of the select input does not take effect at once. The controller first counts ticks of the requested oscillator until that oscillator is trusted. How long it counts depends on the oscillator mode: a short count for the resistor/capacitor and external-clock modes, and a long start-up count for the crystal modes. While it counts, the old source keeps driving the core. The change itself only happens at an instruction boundary.

A sleep request parks the core at the start of an instruction cycle. Any of three wake inputs starts it again. Analog glitch-free muxing of clocks is not modelled here; everything runs on clock enables.

Top module: `clk_switch_sleep_ctl`

## Requirements
- R1: After reset the secondary oscillator is the active source, `q_phase` is 0 (Q1), `sys_clk_en` and `pc_adv` are 0, and the core is awake.
- R2: While awake, `sys_clk_en` is 1 for exactly the cycle after each tick of the active source and 0 otherwise. Ticks of the inactive source have no effect on any output.
- R3: `q_phase` encodes Q1..Q4 as 0..3. It advances by one, wrapping from 3 to 0, in the cycle after each active-source tick taken while awake, and it holds otherwise.
- R4: `pc_adv` is a one-cycle pulse in the same cycle that `q_phase` wraps from Q4 to Q1, and at no other time.
- R5: `sel_main` = 1 requests the main oscillator and 0 requests the secondary one. Until the requested source has settled, the current source keeps driving all outputs.
- R6: For `osc_mode` codes 3, 4, 5 and 6 (the RC, RC with I/O pin, external clock, and external clock with I/O pin modes), the main oscillator is settled after FAST_WAIT (8) of its ticks, counted from the request.
- R7: For `osc_mode` codes 0, 1, 2 and 7 (the crystal modes), the main oscillator is settled after XTAL_WAIT (1024) of its ticks.
- R8: A request to return to the secondary oscillator is settled after SEC_WAIT (8) secondary ticks.
- R9: The handover happens only on an active-source tick taken at Q4. `q_phase` goes to Q1 on that tick, and every later advance follows the new source.
- R10: If `sel_main` goes back to the current source before the handover, the pending switch is dropped and its tick count is discarded.
- R11: A `sleep_req` pulse seen while awake takes effect at the next Q4-to-Q1 advance. From then on `q_phase` stays 0 and `sys_clk_en` and `pc_adv` stay 0.
- R12: While asleep, a high level on `wake_ext_rst`, `wake_wdt` or `wake_irq` wakes the core on the next edge, and the next active tick then advances to Q2. While awake these inputs have no effect, and they do not cancel a pending sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_main | input | 1 | Source select: 1 main, 0 secondary |
| osc_mode | input | 3 | Main oscillator mode code |
| sec_tick | input | 1 | One-cycle tick per secondary oscillator period |
| main_tick | input | 1 | One-cycle tick per main oscillator period |
| sleep_req | input | 1 | Sleep request |
| wake_ext_rst | input | 1 | Wake on external reset |
| wake_wdt | input | 1 | Wake on watchdog reset |
| wake_irq | input | 1 | Wake on interrupt |
| sys_clk_en | output | 1 | System clock enable |
| q_phase | output | 2 | Current instruction phase, 0..3 for Q1..Q4 |
| pc_adv | output | 1 | Instruction-boundary strobe, program counter advance |

## Verification
If the active-source flag is wrong, the outputs show it on the very next tick: `q_phase` follows the wrong oscillator's ticks, or ignores the right one's. If the settle counter is wrong, the handover lands one or more instruction cycles early or late, so it is visible within one instruction cycle after the boundary concerned. A wrong sleep flag shows as a phase change or enable pulse while parked, or as a stall, on the first active tick after it. For these reasons every output is compared against an independent model on every cycle, and directed sequences probe the settle counts one tick short of and exactly at their limits.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} qph_t;

  localparam int MODE_W = 3;

  // Modes with no start-up time-out: RC, RC+IO, ext clock, ext clock+IO
  function automatic logic mode_no_startup(input logic [MODE_W-1:0] m);
    return (m inside {3'd3, 3'd4, 3'd5, 3'd6});
  endfunction
endpackage

// File: rtl/cks_settle.sv
module cks_settle
  import cks_pkg::*;
#(
  parameter int FAST_WAIT = 8,
  parameter int XTAL_WAIT = 1024,
  parameter int SEC_WAIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              want_main,
  input  logic              cur_main,
  input  logic [MODE_W-1:0] mode,
  input  logic              sec_tick,
  input  logic              main_tick,
  output logic              ready
);
  localparam int MAXW_A = (FAST_WAIT > XTAL_WAIT) ? FAST_WAIT : XTAL_WAIT;
  localparam int MAXW   = (MAXW_A > SEC_WAIT) ? MAXW_A : SEC_WAIT;
  localparam int CW     = $clog2(MAXW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          switching;
  logic          tgt_tick;

  always_comb begin
    switching = (want_main != cur_main);
    tgt_tick  = want_main ? main_tick : sec_tick;
    if (!want_main)                 limit = CW'(SEC_WAIT);
    else if (mode_no_startup(mode)) limit = CW'(FAST_WAIT);
    else                            limit = CW'(XTAL_WAIT);
  end

  // count ticks of the requested source; drop the count when no switch is pending
  always_ff @(posedge clk) begin
    if (rst || !switching)               cnt <= '0;
    else if (tgt_tick && cnt < CW'(MAXW)) cnt <= cnt + 1'b1;
  end

  assign ready = switching && (cnt >= limit);

  // R10: a dropped request leaves no count behind
  p_abort_clears_r10: assert property (@(posedge clk) disable iff (rst)
    !switching |=> (cnt == '0));

  // R7: counter never runs past its ceiling
  p_cnt_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(MAXW)) |=> (cnt == CW'(MAXW) || cnt == '0));
endmodule

// File: rtl/cks_phase.sv
module cks_phase
  import cks_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic main_tick,
  input  logic want_main,
  input  logic ready,
  input  logic sleep_req,
  input  logic wake,
  output logic cur_main,
  output logic sys_clk_en,
  output qph_t q,
  output logic pc_adv
);
  logic asleep;
  logic pend;
  logic act_tick;
  logic step;
  logic boundary;

  always_comb begin
    act_tick = cur_main ? main_tick : sec_tick;
    step     = !asleep && act_tick;
    boundary = step && (q == PH_Q4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q          <= PH_Q1;
      sys_clk_en <= 1'b0;
      pc_adv     <= 1'b0;
      cur_main   <= 1'b0;
      asleep     <= 1'b0;
      pend       <= 1'b0;
    end else begin
      sys_clk_en <= step;
      pc_adv     <= boundary;
      if (step) q <= qph_t'(q + 2'd1);
      if (boundary && ready) cur_main <= want_main;
      if (asleep) begin
        if (wake) asleep <= 1'b0;
      end else if (boundary && (pend || sleep_req)) begin
        asleep <= 1'b1;
        pend   <= 1'b0;
      end else if (sleep_req) begin
        pend <= 1'b1;
      end
    end
  end

  // R3: phase only ever moves forward by one
  p_q_step_r3: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> (q == qph_t'($past(q) + 2'd1)));

  // R4: the boundary strobe always lands on Q1
  p_pc_at_q1_r4: assert property (@(posedge clk) disable iff (rst)
    pc_adv |-> (q == PH_Q1));

  // R9: source changes only at an instruction boundary
  p_handover_q1_r9: assert property (@(posedge clk) disable iff (rst)
    (cur_main != $past(cur_main)) |-> (q == PH_Q1 && pc_adv));

  // R11: parked core stays frozen at Q1 with no enables
  p_sleep_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (asleep && $past(asleep)) |-> (q == PH_Q1 && !sys_clk_en && !pc_adv));
endmodule

// File: rtl/clk_switch_sleep_ctl.sv
module clk_switch_sleep_ctl
  import cks_pkg::*;
#(
  parameter int FAST_WAIT = 8,
  parameter int XTAL_WAIT = 1024,
  parameter int SEC_WAIT  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_main,
  input  logic [2:0] osc_mode,
  input  logic       sec_tick,
  input  logic       main_tick,
  input  logic       sleep_req,
  input  logic       wake_ext_rst,
  input  logic       wake_wdt,
  input  logic       wake_irq,
  output logic       sys_clk_en,
  output logic [1:0] q_phase,
  output logic       pc_adv
);
  logic cur_main;
  logic ready;
  logic wake_any;
  qph_t q;

  assign wake_any = wake_ext_rst | wake_wdt | wake_irq;
  assign q_phase  = q;

  cks_settle #(
    .FAST_WAIT (FAST_WAIT),
    .XTAL_WAIT (XTAL_WAIT),
    .SEC_WAIT  (SEC_WAIT)
  ) u_settle (
    .clk       (clk),
    .rst       (rst),
    .want_main (sel_main),
    .cur_main  (cur_main),
    .mode      (osc_mode),
    .sec_tick  (sec_tick),
    .main_tick (main_tick),
    .ready     (ready)
  );

  cks_phase u_phase (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .main_tick  (main_tick),
    .want_main  (sel_main),
    .ready      (ready),
    .sleep_req  (sleep_req),
    .wake       (wake_any),
    .cur_main   (cur_main),
    .sys_clk_en (sys_clk_en),
    .q          (q),
    .pc_adv     (pc_adv)
  );

  // R2: no enable pulse without a tick from some source on the previous edge
  p_en_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    sys_clk_en |-> ($past(sec_tick) || $past(main_tick)));
endmodule

// File: tb/tb_clk_switch_sleep_ctl.sv
module tb_clk_switch_sleep_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_main = 1'b0;
  logic [2:0] osc_mode = 3'd5;
  logic       sec_tick = 1'b0, main_tick = 1'b0, sleep_req = 1'b0;
  logic       wake_ext_rst = 1'b0, wake_wdt = 1'b0, wake_irq = 1'b0;
  logic       sys_clk_en, pc_adv;
  logic [1:0] q_phase;

  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  clk_switch_sleep_ctl dut (
    .clk(clk), .rst(rst), .sel_main(sel_main), .osc_mode(osc_mode),
    .sec_tick(sec_tick), .main_tick(main_tick), .sleep_req(sleep_req),
    .wake_ext_rst(wake_ext_rst), .wake_wdt(wake_wdt), .wake_irq(wake_irq),
    .sys_clk_en(sys_clk_en), .q_phase(q_phase), .pc_adv(pc_adv));

  // reference model built from the requirements
  int m_q, m_cnt;
  bit m_en, m_pc, m_cur, m_sl, m_pend;

  function automatic int settle_len(bit to_main, logic [2:0] md);
    if (!to_main) return 8;                      // R8
    if (md >= 3 && md <= 6) return 8;            // R6
    return 1024;                                 // R7
  endfunction

  always @(posedge clk) begin
    bit act, stp, bnd, sw, rdy;
    if (rst) begin
      m_q <= 0; m_en <= 0; m_pc <= 0; m_cur <= 0; m_sl <= 0; m_pend <= 0; m_cnt <= 0;
    end else begin
      act = m_cur ? main_tick : sec_tick;
      stp = !m_sl && act;
      bnd = stp && m_q == 3;
      sw  = sel_main != m_cur;
      rdy = sw && m_cnt >= settle_len(sel_main, osc_mode);
      m_en <= stp;
      m_pc <= bnd;
      if (stp) m_q <= (m_q + 1) % 4;
      if (bnd && rdy) m_cur <= sel_main;
      if (!sw) m_cnt <= 0;
      else if ((sel_main ? main_tick : sec_tick) && m_cnt < 1024) m_cnt <= m_cnt + 1;
      if (m_sl) begin
        if (wake_ext_rst || wake_wdt || wake_irq) m_sl <= 0;
      end else if (bnd && (m_pend || sleep_req)) begin
        m_sl <= 1; m_pend <= 0;
      end else if (sleep_req) m_pend <= 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (model_on) begin
      chk("R2 sys_clk_en", sys_clk_en, m_en);
      chk("R3 q_phase", q_phase, m_q);
      chk("R4 pc_adv", pc_adv, m_pc);
    end
  endtask

  task automatic tk(bit s, bit m);
    sec_tick = s; main_tick = m;
    cyc();
    sec_tick = 0; main_tick = 0;
  endtask

  task automatic do_reset();
    rst = 1; sel_main = 0; sleep_req = 0;
    wake_ext_rst = 0; wake_wdt = 0; wake_irq = 0;
    cyc(); cyc();
    rst = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 q", q_phase, 0); chk("R1 en", sys_clk_en, 0); chk("R1 pc", pc_adv, 0);

    // --- fast mode switch, R2 R3 R5 R6 R9
    tk(1, 0); chk("R2 en after tick", sys_clk_en, 1); chk("R3 q", q_phase, 1);
    tk(0, 0); chk("R2 en idle", sys_clk_en, 0);
    tk(0, 1); chk("R2 inactive source ignored", q_phase, 1);
    chk("R2 inactive source no enable", sys_clk_en, 0);
    tk(1, 0); tk(1, 0); chk("R3 q at Q4", q_phase, 3);
    sel_main = 1; osc_mode = 3'd5;
    for (int i = 0; i < 7; i++) tk(0, 1);
    chk("R5 old source holds", q_phase, 3);
    tk(1, 0); chk("R3 wrap", q_phase, 0); chk("R4 strobe", pc_adv, 1);
    tk(0, 1); chk("R6 no handover before 8", q_phase, 0);
    tk(1, 0); tk(1, 0); tk(1, 0); chk("R9 Q4 reached", q_phase, 3);
    tk(1, 0); chk("R9 handover to Q1", q_phase, 0);
    tk(0, 1); chk("R6 main active", q_phase, 1);
    tk(1, 0); chk("R5 secondary now ignored", q_phase, 1);

    // --- crystal mode switch, R7
    do_reset();
    sel_main = 1; osc_mode = 3'd1;
    tk(1, 0); tk(1, 0); tk(1, 0);
    for (int i = 0; i < 1023; i++) tk(0, 1);
    tk(1, 0); chk("R7 still secondary after 1023", q_phase, 0);
    tk(0, 1); chk("R7 1024th tick no advance", q_phase, 0);
    tk(1, 0); tk(1, 0); tk(1, 0); tk(1, 0);
    chk("R7 handover at boundary", q_phase, 0);
    tk(0, 1); chk("R7 main active", q_phase, 1);

    // --- abort, R10, and return, R8
    sel_main = 0;
    for (int i = 0; i < 5; i++) tk(1, 0);
    sel_main = 1; cyc(); sel_main = 0;
    for (int i = 0; i < 5; i++) tk(1, 0);
    tk(0, 1); tk(0, 1); tk(0, 1); chk("R10 back at Q1", q_phase, 0);
    tk(1, 0); chk("R10 count was discarded", q_phase, 0);
    tk(1, 0); tk(1, 0);
    tk(0, 1); tk(0, 1); tk(0, 1); tk(0, 1);
    tk(1, 0); chk("R8 secondary active after 8", q_phase, 1);

    // --- sleep and wake, R11 R12
    do_reset();
    tk(1, 0);
    sleep_req = 1; cyc(); sleep_req = 0;
    wake_wdt = 1; cyc(); wake_wdt = 0;
    tk(1, 0); tk(1, 0);
    tk(1, 0); chk("R11 entry boundary q", q_phase, 0); chk("R11 entry strobe", pc_adv, 1);
    tk(1, 0); chk("R11 frozen q", q_phase, 0); chk("R11 no enable", sys_clk_en, 0);
    tk(1, 1); chk("R11 no strobe", pc_adv, 0); chk("R12 wake while awake kept sleep", q_phase, 0);
    wake_irq = 1; cyc(); wake_irq = 0;
    tk(1, 0); chk("R12 resumed q", q_phase, 1); chk("R12 resumed en", sys_clk_en, 1);

    // --- random run against the model
    do_reset();
    model_on = 1;
    for (int i = 0; i < 30000; i++) begin
      sec_tick     = ($urandom % 4) == 0;
      main_tick    = ($urandom % 2) == 0;
      if (($urandom % 300) == 0) sel_main = ~sel_main;
      if (($urandom % 500) == 0) osc_mode = 3'($urandom % 8);
      sleep_req    = ($urandom % 200) == 0;
      wake_ext_rst = ($urandom % 400) == 0;
      wake_wdt     = ($urandom % 400) == 0;
      wake_irq     = ($urandom % 300) == 0;
      cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule